// File: doc/BRIEF.md
# Conditional Jump Evaluation Unit

This unit decides where a packet-filter program continues after a jump-class instruction. Each cycle it can accept one instruction: its 8-bit opcode, the 64-bit value of the destination register, the 64-bit value of the source register, the 32-bit immediate, the index of the current instruction and a signed 16-bit branch displacement. One clock later it reports the index of the next instruction, and whether a branch was taken. It also raises a strobe for a call request, a strobe for program exit, an illegal-opcode flag and an out-of-range flag.

Branches have a single target. When the condition fails, execution falls through to the instruction that follows. The comparison runs either on the full 64-bit operands or on their low 32 bits only, and the opcode's class field picks which. The unit does not fetch instructions and does not carry out calls. It only flags them so that the surrounding sequencer can act.

Top module: `jmp_eval_unit`

## Requirements
- R1: Outputs are registered. `out_valid` is high exactly one cycle after a cycle with `in_valid` high. While `out_valid` is low, every flag is 0 and `next_idx` is 0, and reset clears them all.
- R2: The class field, `opcode[2:0]`, selects the width. 3'h5 compares all 64 bits, and 3'h6 compares only bits 31:0 of both operands, in both the signed and unsigned forms. Any other class value is illegal.
- R3: `opcode[3]` selects the second operand. A 1 selects `src_val`. A 0 selects `imm`, sign-extended from 32 to 64 bits.
- R4: `opcode[7:4]` selects the condition, comparing the destination value with the second operand. The codes are: 1 equal, 5 not equal, 2 unsigned greater, 3 unsigned greater-or-equal, a unsigned less, b unsigned less-or-equal, 6 signed greater, 7 signed greater-or-equal, c signed less, d signed less-or-equal, and 4 taken when the bitwise AND is nonzero.
- R5: A taken branch goes to `cur_idx + 1 + sext(offset)` and sets `taken`. When the condition is false, the next index is `cur_idx + 1` and `taken` is 0.
- R6: Code 0 in class 3'h5 is an unconditional branch. It is always taken.
- R7: Code 8 in class 3'h5 is a call. It sets `call_req`, leaves `taken` at 0 and advances to `cur_idx + 1`.
- R8: Code 9 in class 3'h5 is an exit. It sets `halt_req`, leaves `taken` at 0 and reports `next_idx = cur_idx`.
- R9: Codes 0, 8 and 9 in class 3'h6 are illegal, and so are codes e and f in either class. An illegal opcode sets `illegal` and clears `taken`, `call_req`, `halt_req` and `range_err`. It reports `next_idx = cur_idx + 1`, wrapped to the index width.
- R10: This rule covers legal non-exit instructions. If the chosen next index (the target, or `cur_idx + 1`) is negative or at least 4096, the unit sets `range_err`, clears `taken` and `call_req`, and reports `next_idx = cur_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation code, operand select and class |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| cur_idx | input | 12 | Index of the current instruction |
| offset | input | 16 | Signed branch displacement |
| out_valid | output | 1 | Result present |
| next_idx | output | 12 | Index of the next instruction |
| taken | output | 1 | Branch was taken |
| call_req | output | 1 | Call requested |
| halt_req | output | 1 | Program exit |
| illegal | output | 1 | Opcode not valid for a jump |
| range_err | output | 1 | Next index outside the program |

## Verification
The assertions check several properties on every cycle:
- the one-cycle handshake between `in_valid` and `out_valid`;
- the mutual exclusion of the result flags;
- the index arithmetic for exit, call, out-of-range and fall-through results, and for taken branches, each against the index and offset captured one cycle earlier.

Only the bench can show that the right condition is chosen for each code. The same holds for the sign, width and immediate sign-extension corner cases. The bench covers them with directed operands and with random operands that are often equal or differ only in their upper half, checked against an independent reference model.

// File: rtl/jmp_eval_pkg.sv
// Package: shared codes and types for the jump evaluation unit.
// Assumes the class field is opcode[2:0] and the operation field opcode[7:4].
package jmp_eval_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'h5;
    localparam logic [2:0] CLS_NARROW = 3'h6;

    typedef enum logic [3:0] {
        OP_ALWAYS = 4'h0,
        OP_EQ     = 4'h1,
        OP_UGT    = 4'h2,
        OP_UGE    = 4'h3,
        OP_ANY    = 4'h4,
        OP_NE     = 4'h5,
        OP_SGT    = 4'h6,
        OP_SGE    = 4'h7,
        OP_CALL   = 4'h8,
        OP_EXIT   = 4'h9,
        OP_ULT    = 4'ha,
        OP_ULE    = 4'hb,
        OP_SLT    = 4'hc,
        OP_SLE    = 4'hd,
        OP_RSV_E  = 4'he,
        OP_RSV_F  = 4'hf
    } jop_e;

    typedef struct packed {
        logic eq;   // operands equal
        logic ult;  // unsigned lhs < rhs
        logic slt;  // signed lhs < rhs
        logic any;  // bitwise AND nonzero
    } cmp_flags_t;

endpackage

// File: rtl/jmp_compare.sv
// Module: jmp_compare
// Produces the raw relation flags between two W-bit operands.
// Assumes two's complement for the signed relation. Purely combinational.
module jmp_compare #(
    parameter int W = 64
) (
    input  logic [W-1:0]              lhs,
    input  logic [W-1:0]              rhs,
    output jmp_eval_pkg::cmp_flags_t  flags
);
    // Derive equality, both orderings and the bit-test flag.
    always_comb begin
        flags.eq  = (lhs == rhs);
        flags.ult = (lhs < rhs);
        flags.slt = ($signed(lhs) < $signed(rhs));
        flags.any = |(lhs & rhs);
    end
endmodule

// File: rtl/jmp_decode.sv
// Module: jmp_decode
// Splits the opcode into width, operand select and operation.
// Classifies the operation as conditional, unconditional, call, exit or illegal.
// Assumes only the two jump classes are legal. Purely combinational.
module jmp_decode
    import jmp_eval_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       is_wide,
    output logic       use_reg,
    output jop_e       op,
    output logic       is_cond,
    output logic       is_uncond,
    output logic       is_call,
    output logic       is_exit,
    output logic       is_illegal
);
    logic [2:0] cls;
    logic       cls_ok;
    logic       wide_only;

    // Field extraction.
    always_comb begin
        cls     = opcode[2:0];
        op      = jop_e'(opcode[7:4]);
        use_reg = opcode[3];
        is_wide = (cls == CLS_WIDE);
        cls_ok  = (cls == CLS_WIDE) || (cls == CLS_NARROW);
    end

    // Operation classification and legality.
    always_comb begin
        is_cond   = 1'b0;
        wide_only = 1'b0;
        unique case (op)
            OP_ALWAYS, OP_CALL, OP_EXIT:        wide_only = 1'b1;
            OP_RSV_E, OP_RSV_F:                 is_cond   = 1'b0;
            default:                            is_cond   = 1'b1;
        endcase
        is_illegal = !cls_ok || (op == OP_RSV_E) || (op == OP_RSV_F) ||
                     (wide_only && !is_wide);
        is_uncond  = !is_illegal && (op == OP_ALWAYS);
        is_call    = !is_illegal && (op == OP_CALL);
        is_exit    = !is_illegal && (op == OP_EXIT);
    end
endmodule

// File: rtl/jmp_target.sv
// Module: jmp_target
// Forms the fall-through and branch indices and picks one.
// Reports whether the chosen index lies inside a program of 2**IDX_W slots.
// Assumes OFF_W is a signed displacement relative to the following instruction.
module jmp_target #(
    parameter int IDX_W = 12,
    parameter int OFF_W = 16
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [OFF_W-1:0] offset,
    input  logic             take,
    output logic [IDX_W-1:0] cand_idx,
    output logic             in_range
);
    localparam int TW = ((IDX_W > OFF_W) ? IDX_W : OFF_W) + 2;

    logic signed [TW-1:0] idx_ext;
    logic signed [TW-1:0] off_ext;
    logic signed [TW-1:0] seq_idx;
    logic signed [TW-1:0] br_idx;
    logic signed [TW-1:0] pick;

    // Widen the operands, add and select the candidate.
    always_comb begin
        idx_ext  = $signed(TW'(cur_idx));
        off_ext  = TW'($signed(offset));
        seq_idx  = idx_ext + TW'(1);
        br_idx   = seq_idx + off_ext;
        pick     = take ? br_idx : seq_idx;
        cand_idx = pick[IDX_W-1:0];
        in_range = (pick[TW-1:IDX_W] == '0);
    end
endmodule

// File: rtl/jmp_eval_unit.sv
// Module: jmp_eval_unit (top)
// Evaluates one jump-class instruction per cycle and registers the next index,
// the taken flag and the call, exit, illegal and out-of-range indications.
// Assumes a synchronous active-low reset and a one-cycle result latency.
module jmp_eval_unit
    import jmp_eval_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 32,
    parameter int IDX_W    = 12,
    parameter int OFF_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [OFF_W-1:0]  offset,
    output logic              out_valid,
    output logic [IDX_W-1:0]  next_idx,
    output logic              taken,
    output logic              call_req,
    output logic              halt_req,
    output logic              illegal,
    output logic              range_err
);
    localparam int NCMP = 2;

    logic              is_wide, use_reg, is_cond, is_uncond;
    logic              is_call, is_exit, is_illegal;
    jop_e              op;
    logic [DATA_W-1:0] rhs_val;
    cmp_flags_t        flg_w [NCMP];
    cmp_flags_t        flg;
    logic              cond_hit;
    logic              take_req;
    logic [IDX_W-1:0]  cand_idx;
    logic              in_range;

    jmp_decode u_dec (
        .opcode     (opcode),
        .is_wide    (is_wide),
        .use_reg    (use_reg),
        .op         (op),
        .is_cond    (is_cond),
        .is_uncond  (is_uncond),
        .is_call    (is_call),
        .is_exit    (is_exit),
        .is_illegal (is_illegal)
    );

    // Second operand: source register or sign-extended immediate.
    always_comb begin
        rhs_val = use_reg ? src_val
                          : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end

    // One comparator per supported width; index 0 is full, 1 is narrow.
    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        localparam int CW = (g == 0) ? DATA_W : NARROW_W;
        jmp_compare #(.W(CW)) u_cmp (
            .lhs   (dst_val[CW-1:0]),
            .rhs   (rhs_val[CW-1:0]),
            .flags (flg_w[g])
        );
    end

    // Width select and condition evaluation.
    always_comb begin
        flg = is_wide ? flg_w[0] : flg_w[1];
        unique case (op)
            OP_EQ:   cond_hit = flg.eq;
            OP_NE:   cond_hit = !flg.eq;
            OP_UGT:  cond_hit = !flg.ult && !flg.eq;
            OP_UGE:  cond_hit = !flg.ult;
            OP_ULT:  cond_hit = flg.ult;
            OP_ULE:  cond_hit = flg.ult || flg.eq;
            OP_SGT:  cond_hit = !flg.slt && !flg.eq;
            OP_SGE:  cond_hit = !flg.slt;
            OP_SLT:  cond_hit = flg.slt;
            OP_SLE:  cond_hit = flg.slt || flg.eq;
            OP_ANY:  cond_hit = flg.any;
            default: cond_hit = 1'b0;
        endcase
        take_req = !is_illegal && (is_uncond || (is_cond && cond_hit));
    end

    jmp_target #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_tgt (
        .cur_idx  (cur_idx),
        .offset   (offset),
        .take     (take_req),
        .cand_idx (cand_idx),
        .in_range (in_range)
    );

    // Result register: resolve priority illegal > exit > range > normal.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            next_idx  <= '0;
            taken     <= 1'b0;
            call_req  <= 1'b0;
            halt_req  <= 1'b0;
            illegal   <= 1'b0;
            range_err <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            taken     <= 1'b0;
            call_req  <= 1'b0;
            halt_req  <= 1'b0;
            illegal   <= 1'b0;
            range_err <= 1'b0;
            if (is_illegal) begin
                illegal  <= 1'b1;
                next_idx <= cur_idx + IDX_W'(1);
            end else if (is_exit) begin
                halt_req <= 1'b1;
                next_idx <= cur_idx;
            end else if (!in_range) begin
                range_err <= 1'b1;
                next_idx  <= cur_idx;
            end else begin
                next_idx <= cand_idx;
                taken    <= take_req;
                call_req <= is_call;
            end
        end
    end
endmodule

// File: rtl/jmp_eval_chk.sv
// Module: jmp_eval_chk
// Temporal checks on the jump evaluation unit's ports, attached by bind.
// Assumes the same parameters as the unit it watches.
module jmp_eval_chk #(
    parameter int IDX_W = 12,
    parameter int OFF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IDX_W-1:0] cur_idx,
    input logic [OFF_W-1:0] offset,
    input logic             out_valid,
    input logic [IDX_W-1:0] next_idx,
    input logic             taken,
    input logic             call_req,
    input logic             halt_req,
    input logic             illegal,
    input logic             range_err
);
    logic [IDX_W-1:0] seq_exp;
    logic [IDX_W-1:0] br_exp;

    // Expected indices from the inputs of this cycle, checked one cycle on.
    always_comb begin
        seq_exp = cur_idx + IDX_W'(1);
        br_exp  = cur_idx + IDX_W'(1) + IDX_W'($signed(offset));
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(taken || call_req || halt_req || illegal || range_err));
    p_one_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken, call_req, halt_req, illegal, range_err}));
    p_exit_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (halt_req -> next_idx == $past(cur_idx)));
    p_call_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (call_req -> next_idx == $past(seq_exp)));
    p_range_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (range_err -> next_idx == $past(cur_idx)));
    p_taken_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken -> next_idx == $past(br_exp)));
    p_fall_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((!taken && !halt_req && !range_err) -> next_idx == $past(seq_exp)));
endmodule

bind jmp_eval_unit jmp_eval_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cur_idx   (cur_idx),
    .offset    (offset),
    .out_valid (out_valid),
    .next_idx  (next_idx),
    .taken     (taken),
    .call_req  (call_req),
    .halt_req  (halt_req),
    .illegal   (illegal),
    .range_err (range_err)
);

// File: tb/jmp_eval_unit_tb_top.sv
`timescale 1ns/1ps
module jmp_eval_unit_tb_top;
    localparam int IDX_W = 12;
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0] nxt;
        logic tk, cl, ht, il, re;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [7:0]       opcode;
    logic [63:0]      dst_val, src_val;
    logic [31:0]      imm;
    logic [IDX_W-1:0] cur_idx;
    logic [15:0]      offset;
    logic             out_valid;
    logic [IDX_W-1:0] next_idx;
    logic             taken, call_req, halt_req, illegal, range_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    jmp_eval_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm), .cur_idx(cur_idx),
        .offset(offset), .out_valid(out_valid), .next_idx(next_idx),
        .taken(taken), .call_req(call_req), .halt_req(halt_req),
        .illegal(illegal), .range_err(range_err)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [7:0] opc, input logic [63:0] d,
                                   input logic [63:0] s, input logic [31:0] im,
                                   input logic [IDX_W-1:0] idx, input logic [15:0] off);
        exp_t e;
        logic [2:0]  cls = opc[2:0];
        logic [3:0]  op  = opc[7:4];
        logic [63:0] b   = opc[3] ? s : {{32{im[31]}}, im};
        logic eq, ult, slt, any, c, bad;
        int cand;
        e = '0;
        if (cls == 3'h5) begin
            eq = (d == b); ult = (d < b); slt = ($signed(d) < $signed(b)); any = |(d & b);
        end else begin
            eq = (d[31:0] == b[31:0]); ult = (d[31:0] < b[31:0]);
            slt = ($signed(d[31:0]) < $signed(b[31:0])); any = |(d[31:0] & b[31:0]);
        end
        bad = !(cls == 3'h5 || cls == 3'h6) || op >= 4'he ||
              (cls == 3'h6 && (op == 4'h0 || op == 4'h8 || op == 4'h9));
        case (op)
            4'h0: c = 1'b1;
            4'h1: c = eq;         4'h5: c = !eq;
            4'h2: c = !ult && !eq; 4'h3: c = !ult;
            4'ha: c = ult;        4'hb: c = ult || eq;
            4'h6: c = !slt && !eq; 4'h7: c = !slt;
            4'hc: c = slt;        4'hd: c = slt || eq;
            4'h4: c = any;
            default: c = 1'b0;
        endcase
        if (bad) begin
            e.il = 1'b1; e.nxt = idx + 12'd1;
        end else if (op == 4'h9) begin
            e.ht = 1'b1; e.nxt = idx;
        end else begin
            cand = int'(idx) + 1 + (c ? int'($signed(off)) : 0);
            if (cand < 0 || cand >= DEPTH) begin
                e.re = 1'b1; e.nxt = idx;
            end else begin
                e.nxt = cand[IDX_W-1:0]; e.tk = c; e.cl = (op == 4'h8);
            end
        end
        return e;
    endfunction

    task automatic check_out(input string req, input exp_t e, input logic ev);
        logic [IDX_W+5:0] got, want;
        got  = {out_valid, next_idx, taken, call_req, halt_req, illegal, range_err};
        want = {ev, e};
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, want);
        end
    endtask

    // Drive one instruction at a falling edge and check it at the next one.
    task automatic run(input string req, input logic [7:0] opc, input logic [63:0] d,
                       input logic [63:0] s, input logic [31:0] im,
                       input logic [IDX_W-1:0] idx, input logic [15:0] off);
        in_valid = 1'b1; opcode = opc; dst_val = d; src_val = s; imm = im;
        cur_idx = idx; offset = off;
        @(negedge clk);
        check_out(req, model(opc, d, s, im, idx, off), 1'b1);
    endtask

    initial begin
        #(8ns * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        logic [63:0] d, s;
        logic [31:0] im;
        logic [7:0]  opc;
        logic [15:0] off;
        unused_seed = $urandom(32'h5eed);
        rst_n = 1'b0; in_valid = 1'b1; opcode = 8'h05; dst_val = '0; src_val = '0;
        imm = '0; cur_idx = '0; offset = '0;
        repeat (3) @(negedge clk);
        check_out("R1 reset", '0, 1'b0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check_out("R1 idle", '0, 1'b0);

        run("R4 eq64 taken",        8'h1d, 64'd5, 64'd5, 32'd0, 12'd10, 16'd3);
        run("R2 narrow eq",         8'h1e, 64'h1_0000_0005, 64'd5, 32'd0, 12'd10, 16'd3);
        run("R2 wide ne",           8'h1d, 64'h1_0000_0005, 64'd5, 32'd0, 12'd10, 16'd3);
        run("R2 class illegal",     8'h14, 64'd0, 64'd0, 32'd0, 12'd20, 16'd1);
        run("R3 imm sext",          8'h15, '1, 64'd0, 32'hffff_ffff, 12'd30, 16'd4);
        run("R3 reg select",        8'h1d, '1, 64'h0000_0000_ffff_ffff, 32'hffff_ffff, 12'd30, 16'd4);
        run("R4 sgt",               8'h6d, 64'd1, '1, 32'd0, 12'd40, 16'd2);
        run("R4 ugt",               8'h2d, 64'd1, '1, 32'd0, 12'd40, 16'd2);
        run("R4 narrow slt",        8'hce, 64'h0000_0000_8000_0000, 64'd1, 32'd0, 12'd40, 16'd2);
        run("R4 set hit",           8'h4d, 64'h10, 64'h30, 32'd0, 12'd50, 16'd5);
        run("R4 set miss",          8'h4d, 64'h10, 64'h20, 32'd0, 12'd50, 16'd5);
        run("R5 fall through",      8'h5d, 64'd9, 64'd9, 32'd0, 12'd60, 16'd7);
        run("R6 always back",       8'h05, 64'd0, 64'd0, 32'd0, 12'd100, 16'hffce);
        run("R7 call",              8'h85, 64'd0, 64'd0, 32'd0, 12'd7, 16'd9);
        run("R8 exit",              8'h95, 64'd0, 64'd0, 32'd0, 12'd7, 16'd9);
        run("R9 always narrow",     8'h06, 64'd0, 64'd0, 32'd0, 12'd7, 16'd9);
        run("R9 reserved code",     8'he5, 64'd0, 64'd0, 32'd0, 12'd7, 16'd9);
        run("R9 wrap",              8'h86, 64'd0, 64'd0, 32'd0, 12'd4095, 16'd0);
        run("R10 below zero",       8'h05, 64'd0, 64'd0, 32'd0, 12'd5, 16'hfff9);
        run("R10 at depth",         8'h05, 64'd0, 64'd0, 32'd0, 12'd4000, 16'd95);
        run("R10 last slot ok",     8'h05, 64'd0, 64'd0, 32'd0, 12'd4000, 16'd94);
        run("R10 fall past end",    8'h1d, 64'd1, 64'd2, 32'd0, 12'd4095, 16'd0);
        run("R10 call past end",    8'h85, 64'd0, 64'd0, 32'd0, 12'd4095, 16'd0);
        in_valid = 1'b0;
        @(negedge clk);
        check_out("R1 idle after", '0, 1'b0);

        for (int i = 0; i < 1500; i++) begin
            int k = $urandom % 8;
            opc[7:4] = 4'($urandom);
            opc[3]   = 1'($urandom);
            opc[2:0] = (k < 3) ? 3'h5 : (k < 6) ? 3'h6 : 3'($urandom);
            d = {$urandom, $urandom};
            case ($urandom % 4)
                0: s = d;
                1: s = {~d[63:32], d[31:0]};
                2: s = {$urandom, $urandom};
                default: s = d + 64'($urandom % 3) - 64'd1;
            endcase
            im  = ($urandom % 2 == 0) ? d[31:0] : $urandom;
            off = ($urandom % 3 == 0) ? 16'($urandom) : 16'(int'($urandom % 64) - 32);
            run("R2/R3/R4/R5 random", opc, d, s, im, IDX_W'($urandom), off);
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule